// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes frames that arrive as a byte stream and stores them in a circular receive region of an external byte-wide SRAM. Each input byte comes with a valid strobe. The final byte of a frame also carries an end marker and a status byte. Every stored frame starts with a four-byte header. The block reserves the header slot when the frame begins and writes it only after the final byte has arrived. Until then a reader that follows the committed write pointer cannot see the frame.

After each frame the committed write pointer moves to the next start address. That address is rounded up to the granule of the host bus width (1, 2 or 4 bytes). The ring size depends on the switch port configuration, and the pointer wraps to zero at the top of the region. The host returns its read pointer to the block. The block then reports the free space, keeping one granule empty so that full and empty can be told apart. A frame that does not fit is discarded and reported, and the write pointer stays where it was.

The source must leave at least four idle cycles after each frame's final byte. Bytes presented during that gap are not stored.

Top module: `rx_ring_writer`

## Requirements
- R1: Every SRAM write address is below the active region size R. Data bytes and header bytes that pass address R-1 continue at address 0.
- R2: For a frame stored at base b, the header bytes are written as follows, all addresses modulo R: address b gets 01h; b+1 gets the status byte presented with the final byte; b+2 gets count[7:0]; b+3 gets count[15:8].
- R3: Byte i of a frame (counting from 0) is stored at (b+4+i) mod R. The count equals the number of bytes in the frame, including its trailing CRC bytes.
- R4: cfg_bus_mode selects the granule: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. After a stored frame, wr_ptr equals ((b+4+count) mod R) rounded up to a multiple of the granule, taken modulo R.
- R5: R equals parameter R_3P (default 7680) when cfg_two_port is 0, and parameter R_2P (default 7936) when cfg_two_port is 1.
- R6: free_bytes equals R - ((wr_ptr - host_rd_ptr) mod R) - granule. It responds to host_rd_ptr in the same cycle.
- R7: With host_rd_ptr held, a frame is stored only if count+4 is no larger than free_bytes at its first byte. Otherwise frame_drop is high for one cycle, the cycle after the final byte, wr_ptr keeps its value, and the four header bytes are left untouched.
- R8: A stored frame's header is written in the four cycles after its final byte, and frame_done is high in the fifth cycle after that byte's cycle. wr_ptr changes only in a cycle where frame_done is high.
- R9: While rst_n is low and in the first cycle after it, the outputs hold these values: wr_ptr is 0, frame_done and frame_drop are low, no write is issued while rx_valid is low, and free_bytes is R minus the granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_two_port | input | 1 | Selects region size R_2P (1) or R_3P (0) |
| cfg_bus_mode | input | 2 | Host bus width: 0 byte, 1 word, 2/3 double word |
| rx_valid | input | 1 | Input byte valid |
| rx_data | input | 8 | Input byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_status | input | 8 | Frame status, sampled with the final byte |
| host_rd_ptr | input | AW | Host read pointer inside the region |
| ram_we | output | 1 | SRAM byte write enable |
| ram_addr | output | AW | SRAM byte address |
| ram_wdata | output | 8 | SRAM write data |
| wr_ptr | output | AW | Committed write pointer (start of next frame) |
| free_bytes | output | AW+1 | Free space usable by the next frame |
| frame_done | output | 1 | One-cycle pulse when a frame is committed |
| frame_drop | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The bench runs frames of every length from 1 to 14 bytes under each region size and bus mode, with small rings. The host pointer lags behind, so frames wrap at all byte offsets and some are refused. A wrong modulo reduction would put header or data bytes outside the region, or would skip address 0 after a wrap. A rounding error would leave wr_ptr on an odd or non-quad address, or would let it reach R instead of 0.

Exact-fit and one-byte-over frames probe the free-space rule, including the reserved granule. An off-by-one there either overwrites unread data or refuses a frame that fits. On refused frames the bench confirms that the header slot keeps its old bytes and the pointer keeps its old value. Any early header write or pointer rewind fault shows up there.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

   typedef enum logic [1:0] {
      BM_BYTE  = 2'd0,
      BM_WORD  = 2'd1,
      BM_DWORD = 2'd2,
      BM_QUAD  = 2'd3
   } bus_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_SKIP = 2'd2,
      ST_HDR  = 2'd3
   } wr_state_e;

   localparam logic [7:0] HDR_MARK  = 8'h01;
   localparam int         HDR_BYTES = 4;

   // log2 of the start granule for a bus mode
   function automatic logic [1:0] granule_lg(input logic [1:0] mode);
      case (mode)
         BM_BYTE: granule_lg = 2'd0;
         BM_WORD: granule_lg = 2'd1;
         default: granule_lg = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/rrw_ring_add.sv
// base + inc reduced modulo region; requires base < region and inc < 2*region - base
module rrw_ring_add #(
   parameter int AW = 13
) (
   input  logic [AW-1:0] base,
   input  logic [AW:0]   inc,
   input  logic [AW:0]   region,
   output logic [AW-1:0] sum
);
   logic [AW+1:0] raw;
   logic [AW+1:0] lim;

   always_comb begin
      raw = {2'b00, base} + {1'b0, inc};
      lim = {1'b0, region};
      sum = (raw >= lim) ? AW'(raw - lim) : AW'(raw);
   end
endmodule

// File: rtl/rrw_space.sv
// free space between committed write pointer and host read pointer
module rrw_space #(
   parameter int AW = 13
) (
   input  logic [AW-1:0] wr_base,
   input  logic [AW-1:0] rd_ptr,
   input  logic [AW:0]   region,
   input  logic [2:0]    granule,
   output logic [AW:0]   free_bytes
);
   logic [AW:0] used;

   always_comb begin
      if (wr_base >= rd_ptr)
         used = {1'b0, wr_base} - {1'b0, rd_ptr};
      else
         used = {1'b0, wr_base} + region - {1'b0, rd_ptr};
      free_bytes = region - used - (AW+1)'(granule);
   end
endmodule

// File: rtl/rrw_align.sv
// round a ring address up to the bus granule, folding the top back to zero
module rrw_align #(
   parameter int AW     = 13,
   parameter int MAX_LG = 2
) (
   input  logic [AW-1:0] addr_in,
   input  logic [1:0]    lg_sel,
   input  logic [AW:0]   region,
   output logic [AW-1:0] addr_out
);
   logic [AW:0] cand [MAX_LG+1];

   for (genvar g = 0; g <= MAX_LG; g++) begin : g_gran
      localparam int          U    = 1 << g;
      localparam logic [AW:0] UM1  = (AW+1)'(U - 1);
      logic [AW:0] bumped;
      always_comb begin
         bumped  = {1'b0, addr_in} + UM1;
         cand[g] = (bumped >> g) << g;
      end
   end

   logic [AW:0] picked;

   always_comb begin
      picked = cand[0];
      for (int k = 1; k <= MAX_LG; k++)
         if (lg_sel == 2'(k)) picked = cand[k];
      addr_out = (picked >= region) ? '0 : AW'(picked);
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rrw_pkg::*;
#(
   parameter int   R_3P   = 7680,
   parameter int   R_2P   = 7936,
   parameter int   CNT_W  = 16,
   localparam int  R_MAX  = (R_3P > R_2P) ? R_3P : R_2P,
   localparam int  AW     = $clog2(R_MAX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_two_port,
   input  logic [1:0]    cfg_bus_mode,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic [7:0]    rx_status,
   input  logic [AW-1:0] host_rd_ptr,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata,
   output logic [AW-1:0] wr_ptr,
   output logic [AW:0]   free_bytes,
   output logic          frame_done,
   output logic          frame_drop
);

   // elaboration checks
   if (R_3P % 4 != 0 || R_2P % 4 != 0) begin : g_bad_mult
      $error("region sizes must be multiples of four bytes");
   end
   if (R_3P < 16 || R_2P < 16) begin : g_bad_small
      $error("region sizes must be at least sixteen bytes");
   end
   if (CNT_W < AW + 1 || CNT_W > 16) begin : g_bad_cnt
      $error("count field width must cover the region and fit two bytes");
   end

   localparam logic [AW:0] RG_3P = (AW+1)'(R_3P);
   localparam logic [AW:0] RG_2P = (AW+1)'(R_2P);
   localparam logic [AW:0] HDR_W = (AW+1)'(HDR_BYTES);

   wr_state_e      state_q;
   logic [AW-1:0]  base_q;
   logic [AW-1:0]  dptr_q;
   logic [AW:0]    cnt_q;
   logic [7:0]     stat_q;
   logic [1:0]     hidx_q;
   logic           done_q;
   logic           drop_q;

   logic [AW:0]    region_sz;
   logic [1:0]     lg;
   logic [2:0]     granule;
   logic           hdr_phase;

   assign region_sz = cfg_two_port ? RG_2P : RG_3P;
   assign lg        = granule_lg(cfg_bus_mode);
   assign granule   = 3'(1) << lg;
   assign hdr_phase = (state_q == ST_HDR);

   rrw_space #(.AW(AW)) space_i (
      .wr_base    (base_q),
      .rd_ptr     (host_rd_ptr),
      .region     (region_sz),
      .granule    (granule),
      .free_bytes (free_bytes)
   );

   // address of first data byte, behind the reserved header slot
   logic [AW-1:0] first_addr;
   rrw_ring_add #(.AW(AW)) first_i (
      .base (base_q), .inc (HDR_W), .region (region_sz), .sum (first_addr)
   );

   logic [AW-1:0] data_addr;
   logic [AW-1:0] data_next;
   assign data_addr = (state_q == ST_IDLE) ? first_addr : dptr_q;

   rrw_ring_add #(.AW(AW)) next_i (
      .base (data_addr), .inc ((AW+1)'(1)), .region (region_sz), .sum (data_next)
   );

   logic [AW-1:0] hdr_addr;
   rrw_ring_add #(.AW(AW)) hdr_i (
      .base (base_q), .inc ((AW+1)'(hidx_q)), .region (region_sz), .sum (hdr_addr)
   );

   logic [AW-1:0] end_addr;
   rrw_ring_add #(.AW(AW)) end_i (
      .base (base_q), .inc (cnt_q + HDR_W), .region (region_sz), .sum (end_addr)
   );

   logic [AW-1:0] next_base;
   rrw_align #(.AW(AW), .MAX_LG(2)) align_i (
      .addr_in (end_addr), .lg_sel (lg), .region (region_sz), .addr_out (next_base)
   );

   // room check: header plus every byte taken so far plus this one
   logic [AW+1:0] need;
   logic          fits;
   logic          in_frame;

   assign in_frame = (state_q == ST_IDLE) || (state_q == ST_DATA);

   always_comb begin
      need = {1'b0, ((state_q == ST_DATA) ? cnt_q : '0)} + (AW+2)'(HDR_BYTES + 1);
      fits = need <= {1'b0, free_bytes};
   end

   // header byte lane
   logic [CNT_W-1:0] cnt_field;
   logic [15:0]      cnt_wide;
   logic [7:0]       hdr_byte;

   assign cnt_field = CNT_W'(cnt_q);
   assign cnt_wide  = 16'(cnt_field);

   always_comb begin
      case (hidx_q)
         2'd0:    hdr_byte = HDR_MARK;
         2'd1:    hdr_byte = stat_q;
         2'd2:    hdr_byte = cnt_wide[7:0];
         default: hdr_byte = cnt_wide[15:8];
      endcase
   end

   always_comb begin
      ram_we    = 1'b0;
      ram_addr  = data_addr;
      ram_wdata = rx_data;
      if (hdr_phase) begin
         ram_we    = 1'b1;
         ram_addr  = hdr_addr;
         ram_wdata = hdr_byte;
      end else if (in_frame && rx_valid && fits) begin
         ram_we = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         dptr_q  <= '0;
         cnt_q   <= '0;
         stat_q  <= '0;
         hidx_q  <= '0;
         done_q  <= 1'b0;
         drop_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         drop_q <= 1'b0;
         case (state_q)
            ST_IDLE, ST_DATA: begin
               if (rx_valid) begin
                  if (fits) begin
                     dptr_q <= data_next;
                     cnt_q  <= (state_q == ST_IDLE) ? (AW+1)'(1) : cnt_q + 1'b1;
                     if (rx_last) begin
                        stat_q  <= rx_status;
                        hidx_q  <= '0;
                        state_q <= ST_HDR;
                     end else begin
                        state_q <= ST_DATA;
                     end
                  end else if (rx_last) begin
                     drop_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            ST_SKIP: begin
               if (rx_valid && rx_last) begin
                  drop_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               hidx_q <= hidx_q + 2'd1;
               if (hidx_q == 2'd3) begin
                  base_q  <= next_base;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign wr_ptr     = base_q;
   assign frame_done = done_q;
   assign frame_drop = drop_q;

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
   parameter int AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW:0]   region,
   input logic [1:0]    cfg_bus_mode,
   input logic          ram_we,
   input logic [AW-1:0] ram_addr,
   input logic [AW-1:0] wr_ptr,
   input logic [AW:0]   free_bytes,
   input logic          frame_done,
   input logic          frame_drop,
   input logic          hdr_phase
);

   assert_addr_in_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ({1'b0, ram_addr} < region));

   assert_wrptr_in_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, wr_ptr} < region);

   assert_hdr_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_phase |-> ram_we);

   assert_even_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && cfg_bus_mode != 2'd0) |-> (wr_ptr[0] == 1'b0));

   assert_quad_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && cfg_bus_mode[1]) |-> (wr_ptr[1:0] == 2'b00));

   assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      free_bytes < region);

   assert_done_drop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_done && frame_drop));

   assert_ptr_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr != $past(wr_ptr)) |-> frame_done);

   assert_no_hdr_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !hdr_phase);

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .region       (region_sz),
   .cfg_bus_mode (cfg_bus_mode),
   .ram_we       (ram_we),
   .ram_addr     (ram_addr),
   .wr_ptr       (wr_ptr),
   .free_bytes   (free_bytes),
   .frame_done   (frame_done),
   .frame_drop   (frame_drop),
   .hdr_phase    (hdr_phase)
);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;

   localparam int RA = 40;
   localparam int RB = 44;
   localparam int AW = $clog2(RB);
   localparam int MEMN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_two_port = 1'b0;
   logic [1:0]    cfg_bus_mode = 2'd0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          rx_last = 1'b0;
   logic [7:0]    rx_status = '0;
   logic [AW-1:0] host_rd_ptr = '0;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;
   logic [AW-1:0] wr_ptr;
   logic [AW:0]   free_bytes;
   logic          frame_done;
   logic          frame_drop;

   rx_ring_writer #(.R_3P(RA), .R_2P(RB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_two_port(cfg_two_port), .cfg_bus_mode(cfg_bus_mode),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_status(rx_status),
      .host_rd_ptr(host_rd_ptr), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .wr_ptr(wr_ptr), .free_bytes(free_bytes), .frame_done(frame_done), .frame_drop(frame_drop)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cur_r = RA;
   int wild_writes = 0;
   logic [7:0] shadow [MEMN];

   always @(posedge clk) begin
      if (ram_we) begin
         shadow[ram_addr] <= ram_wdata;
         if (int'(ram_addr) >= cur_r) wild_writes <= wild_writes + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rx_valid = 1'b0;
      rx_last = 1'b0;
      host_rd_ptr = '0;
      repeat (3) @(negedge clk);
      check(wr_ptr == '0, "R9 wr_ptr in reset", int'(wr_ptr), 0);
      check(!frame_done && !frame_drop, "R9 pulses in reset", int'({frame_done, frame_drop}), 0);
      check(!ram_we, "R9 no write in reset", int'(ram_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   int wp, rd, gran;

   task automatic run_frame(input int len, input int st);
      int free_e, lat, new_wp;
      bit accept, seen_done, seen_drop;
      logic [7:0] snap [4];
      for (int k = 0; k < 4; k++) snap[k] = shadow[(wp + k) % cur_r];
      free_e = cur_r - ((wp - rd + cur_r) % cur_r) - gran;
      check(int'(free_bytes) == free_e, "R6 free before frame", int'(free_bytes), free_e);
      accept = (len + 4 <= free_e);
      for (int i = 0; i < len; i++) begin
         rx_valid  = 1'b1;
         rx_data   = 8'((len * 13 + i * 5 + 3) & 255);
         rx_last   = (i == len - 1);
         rx_status = 8'(st);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
      lat = 0;
      seen_done = 1'b0;
      seen_drop = 1'b0;
      for (int w = 1; w <= 10; w++) begin
         if (frame_done || frame_drop) begin
            seen_done = frame_done;
            seen_drop = frame_drop;
            lat = w;
            break;
         end
         @(negedge clk);
      end
      check(wild_writes == 0, "R1 write outside region", wild_writes, 0);
      if (accept) begin
         check(seen_done && lat == 5, "R8 done latency", lat, 5);
         check(shadow[wp % cur_r] == 8'h01, "R2 marker", int'(shadow[wp % cur_r]), 1);
         check(shadow[(wp + 1) % cur_r] == 8'(st), "R2 status", int'(shadow[(wp + 1) % cur_r]), st);
         check(shadow[(wp + 2) % cur_r] == 8'(len), "R2 count low", int'(shadow[(wp + 2) % cur_r]), len);
         check(shadow[(wp + 3) % cur_r] == 8'h00, "R2 count high", int'(shadow[(wp + 3) % cur_r]), 0);
         for (int i = 0; i < len; i++) begin
            int a, e;
            a = (wp + 4 + i) % cur_r;
            e = (len * 13 + i * 5 + 3) & 255;
            check(int'(shadow[a]) == e, "R3 data byte (R1 wrap)", int'(shadow[a]), e);
         end
         new_wp = (wp + 4 + len) % cur_r;
         new_wp = ((new_wp + gran - 1) / gran * gran) % cur_r;
         check(int'(wr_ptr) == new_wp, "R4 next start", int'(wr_ptr), new_wp);
         wp = new_wp;
      end else begin
         check(seen_drop && lat == 1, "R7 drop latency", lat, 1);
         check(int'(wr_ptr) == wp, "R7 pointer kept", int'(wr_ptr), wp);
         for (int k = 0; k < 4; k++)
            check(shadow[(wp + k) % cur_r] == snap[k], "R7 header untouched",
                  int'(shadow[(wp + k) % cur_r]), int'(snap[k]));
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(20.0 * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEMN; i++) shadow[i] = 8'hEE;
      for (int tp = 0; tp < 2; tp++) begin
         for (int bm = 0; bm < 4; bm++) begin
            cfg_two_port = tp[0];
            cfg_bus_mode = 2'(bm);
            cur_r = tp ? RB : RA;   // R5
            gran  = (bm == 0) ? 1 : (bm == 1) ? 2 : 4;
            do_reset();
            check(int'(free_bytes) == cur_r - gran, "R9 R5 free after reset",
                  int'(free_bytes), cur_r - gran);
            wp = 0;
            rd = 0;
            for (int len = 1; len <= 14; len++) begin
               run_frame(len, 8'h40 + len + bm);
               if (len % 3 == 2) begin
                  rd = wp;
                  host_rd_ptr = AW'(rd);
                  #1;
                  check(int'(free_bytes) == cur_r - gran, "R6 free after catch-up",
                        int'(free_bytes), cur_r - gran);
               end
            end
            // exact fit then one byte over (R7)
            do_reset();
            wp = 0; rd = 0;
            run_frame(cur_r - gran - 4, 8'h81);
            do_reset();
            wp = 0; rd = 0;
            run_frame(cur_r - gran - 3, 8'h82);
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule